// File: doc/BRIEF.md
# Dual-Port Byte-Lane Synchronous RAM

This block is a two-port static memory of 18-bit words in which either port may read or write any location at any time, including the location the other port is touching in the same cycle. Each word is split into two 9-bit byte lanes that can be written and read separately. Each port registers its address, write data and controls on the rising clock edge. Two chip-enable inputs, active-low lane selects, a read/write strobe and an asynchronous output enable control each port.

A per-port mode input selects one of two read modes. In flow-through mode the stored word for the registered address is presented in the same cycle. In pipelined mode the word goes through one more register. In that mode the chip-enable decode and the read/write strobe also take one extra stage, while the lane selects still take only one. The output bus is modelled as read data plus one drive flag per lane, in place of tri-state pins.

Both ports run on one shared clock. The depth is set by the address-width parameter: 12 gives 4K words and 13 gives 8K words.

Top module: `dual_lane_ram`

## Requirements
- R1: A port is selected only when its ce0_n input is 0 and its ce1 input is 1. A deselected port writes nothing. In flow-through mode its drive flags are 0 after the next edge.
- R2: A selected port with rw = 0 writes only the lanes whose lane_n bit is 0. Bit 1 of lane_n selects the upper lane, data bits 17..9. Bit 0 selects the lower lane, bits 8..0. Lanes whose bit is 1 keep their old contents.
- R3: A selected port with rw = 1 drives the lanes whose lane_n bit is 0, but only while oe_n is 0. Drive bit 1 is the upper lane and drive bit 0 is the lower lane. An undriven lane reads as zero on rdata.
- R4: oe_n gates the drive flags without any clock edge. Raising it clears both flags, and lowering it restores them.
- R5: In flow-through mode (pipe = 0), the word at the address sampled on edge n appears on rdata after edge n.
- R6: In pipelined mode (pipe = 1), the word at the address sampled on edge n appears on rdata after edge n+1.
- R7: In pipelined mode, a change of chip-enable state sampled on edge n reaches the drive flags after edge n+1. In flow-through mode it reaches them after edge n.
- R8: In both modes, a change of lane_n sampled on edge n reaches the drive flags after edge n.
- R9: The pipe input acts without a clock and is independent for each port. Changing it switches rdata between the two read stages at once.
- R10: A word written by one port is returned to the other port by any read sampled on a later edge. A read sampled on the same edge may return either the old or the new word.
- R11: A synchronous active-low reset clears both ports' drive flags. It does not change the stored words.
- R12: The address width ADDR_W sets the depth to 2**ADDR_W words, and every address up to the top one is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_lane_n | input | 2 | Port A lane selects, active low (bit 1 = upper) |
| a_rw | input | 1 | Port A 1 = read, 0 = write |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A read mode, 1 = pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data, zero in undriven lanes |
| a_drive | output | 2 | Port A per-lane drive flags |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_lane_n | input | 2 | Port B lane selects, active low (bit 1 = upper) |
| b_rw | input | 1 | Port B 1 = read, 0 = write |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B read mode, 1 = pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data, zero in undriven lanes |
| b_drive | output | 2 | Port B per-lane drive flags |

## Verification
A stuck or mistimed chip-enable stage shows up on the drive flags. In pipelined mode it appears exactly one cycle early or late after a deselect or reselect, and in flow-through mode it appears on the first edge. A wrong lane-write mask leaves a corrupted half-word that surfaces on the next read of that address from either port, one cycle after the read is issued in flow-through mode and two cycles after in pipelined mode. An address or read-stage fault appears during a full sweep as a mismatch at the first affected address, so the sweeps cover every location in both read modes.

// File: rtl/dpram_pkg.sv
// Package: shared widths and types for the dual-port lane RAM.
// Assumes two equal lanes that together make up the word.
package dpram_pkg;
    parameter int LANE_W = 9;
    parameter int LANES  = 2;
    parameter int WORD_W = LANE_W * LANES;

    typedef logic [LANES-1:0]  lane_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dpr_store.sv
// Module: dpr_store
// Word storage split into per-lane banks, with two write ports and two
// combinational read ports. Assumes one clock for both writers. When both
// ports write the same lane of the same word, port B's value is kept
// (the result is undefined at the block level).
module dpr_store
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_t             a_we,
    input  logic [ADDR_W-1:0] a_waddr,
    input  word_t             a_wdata,
    input  lane_t             b_we,
    input  logic [ADDR_W-1:0] b_waddr,
    input  word_t             b_wdata,
    input  logic [ADDR_W-1:0] a_raddr,
    input  logic [ADDR_W-1:0] b_raddr,
    output word_t             a_rword,
    output word_t             b_rword
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        logic [LANE_W-1:0] bank [DEPTH];

        // Commit this lane's writes, port B last.
        always_ff @(posedge clk) begin
            if (a_we[g]) bank[a_waddr] <= a_wdata[LO +: LANE_W];
            if (b_we[g]) bank[b_waddr] <= b_wdata[LO +: LANE_W];
        end

        // Present both read words for this lane.
        assign a_rword[LO +: LANE_W] = bank[a_raddr];
        assign b_rword[LO +: LANE_W] = bank[b_raddr];

        // R2: an enabled lane write by port A lands in the bank unless B collides.
        a_r2_lane_commit: assert property (@(posedge clk) disable iff (!rst_n)
            (a_we[g] && !(b_we[g] && b_waddr == a_waddr))
            |=> (bank[$past(a_waddr)] == $past(a_wdata[LO +: LANE_W])));
    end
endmodule

// File: rtl/dpr_port.sv
// Module: dpr_port
// One access port: samples the controls, decodes the lane writes, and holds
// the flow-through and pipelined read stages. The chip-enable decode and the
// read strobe get a second register stage for pipelined mode; the lane
// selects are registered once. Assumes that pipe and oe_n may change at any
// time and act combinationally.
module dpr_port
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  lane_t             lane_n,
    input  logic              rw,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  word_t             rword,
    output lane_t             we,
    output logic [ADDR_W-1:0] waddr,
    output word_t             wdata_o,
    output logic [ADDR_W-1:0] raddr,
    output word_t             rdata,
    output lane_t             drive
);
    logic              sel_in;
    logic [ADDR_W-1:0] addr_q;
    logic              sel_q1, rd_q1, sel_q2, rd_q2;
    lane_t             lane_q;
    word_t             data_p;
    logic              stage_on;
    word_t             word_sel;

    // Decode this cycle's chip enables and lane write mask.
    always_comb begin
        sel_in = !ce0_n && ce1;
        we     = (sel_in && !rw) ? ~lane_n : '0;
    end

    assign waddr   = addr;
    assign wdata_o = wdata;
    assign raddr   = addr_q;

    // Sample controls and move the pipelined read stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            sel_q1 <= 1'b0;
            rd_q1  <= 1'b0;
            sel_q2 <= 1'b0;
            rd_q2  <= 1'b0;
            lane_q <= '0;
            data_p <= '0;
        end else begin
            addr_q <= addr;
            sel_q1 <= sel_in;
            rd_q1  <= rw;
            sel_q2 <= sel_q1;
            rd_q2  <= rd_q1;
            lane_q <= ~lane_n;
            data_p <= rword;
        end
    end

    // Pick the stage for the current mode and gate the lane drivers.
    always_comb begin
        stage_on = pipe ? (sel_q2 && rd_q2) : (sel_q1 && rd_q1);
        word_sel = pipe ? data_p : rword;
        drive    = {LANES{stage_on && !oe_n}} & lane_q;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_out
        // Zero the lanes that are not driven.
        assign rdata[g*LANE_W +: LANE_W] = drive[g] ? word_sel[g*LANE_W +: LANE_W] : '0;

        // R8: a driven lane had its select low on the previous edge.
        a_r8_lane_stage: assert property (@(posedge clk) disable iff (!rst_n)
            drive[g] |-> !$past(lane_n[g]));
    end

    // R1: flow-through deselect clears the drivers after one edge.
    a_r1_flow_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_in |=> (pipe || drive == '0));

    // R7: pipelined deselect clears the drivers after two edges.
    a_r7_pipe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_in |=> ##1 (!pipe || drive == '0));

    // R3: no lane drives while output enable is high.
    a_r3_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> drive == '0);
endmodule

// File: rtl/dual_lane_ram.sv
// Module: dual_lane_ram
// Top: two identical ports sharing one lane-banked storage array.
// Assumes both ports run on the same clock and share one synchronous
// active-low reset that clears only the port control state.
module dual_lane_ram
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_ce0_n,
    input  logic              a_ce1,
    input  logic [1:0]        a_lane_n,
    input  logic              a_rw,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [17:0]       a_wdata,
    output logic [17:0]       a_rdata,
    output logic [1:0]        a_drive,
    input  logic              b_ce0_n,
    input  logic              b_ce1,
    input  logic [1:0]        b_lane_n,
    input  logic              b_rw,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [17:0]       b_wdata,
    output logic [17:0]       b_rdata,
    output logic [1:0]        b_drive
);
    lane_t             a_we, b_we;
    logic [ADDR_W-1:0] a_waddr, b_waddr, a_raddr, b_raddr;
    word_t             a_wd, b_wd, a_rword, b_rword;

    dpr_port #(.ADDR_W(ADDR_W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .ce0_n(a_ce0_n), .ce1(a_ce1),
        .lane_n(a_lane_n), .rw(a_rw), .oe_n(a_oe_n), .pipe(a_pipe),
        .addr(a_addr), .wdata(a_wdata), .rword(a_rword),
        .we(a_we), .waddr(a_waddr), .wdata_o(a_wd), .raddr(a_raddr),
        .rdata(a_rdata), .drive(a_drive)
    );

    dpr_port #(.ADDR_W(ADDR_W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .ce0_n(b_ce0_n), .ce1(b_ce1),
        .lane_n(b_lane_n), .rw(b_rw), .oe_n(b_oe_n), .pipe(b_pipe),
        .addr(b_addr), .wdata(b_wdata), .rword(b_rword),
        .we(b_we), .waddr(b_waddr), .wdata_o(b_wd), .raddr(b_raddr),
        .rdata(b_rdata), .drive(b_drive)
    );

    dpr_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_we(a_we), .a_waddr(a_waddr), .a_wdata(a_wd),
        .b_we(b_we), .b_waddr(b_waddr), .b_wdata(b_wd),
        .a_raddr(a_raddr), .b_raddr(b_raddr),
        .a_rword(a_rword), .b_rword(b_rword)
    );
endmodule

// File: tb/sim_dual_lane_ram.sv
// Bench: sweeps every address in both read modes and walks the lane,
// enable, output-enable, mode and reset corner cases. Expected words come
// from a bench-side model filled by an arithmetic pattern.
module sim_dual_lane_ram;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_ce0_n = 1'b1, a_ce1 = 1'b1, a_rw = 1'b1, a_oe_n = 1'b0, a_pipe = 1'b0;
    logic b_ce0_n = 1'b1, b_ce1 = 1'b1, b_rw = 1'b1, b_oe_n = 1'b0, b_pipe = 1'b0;
    logic [1:0]    a_lane_n = 2'b00, b_lane_n = 2'b00;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [17:0]   a_wdata = '0, b_wdata = '0;
    logic [17:0]   a_rdata, b_rdata;
    logic [1:0]    a_drive, b_drive;

    logic [17:0] model [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_lane_ram #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_ce0_n(a_ce0_n), .a_ce1(a_ce1), .a_lane_n(a_lane_n), .a_rw(a_rw),
        .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_drive(a_drive),
        .b_ce0_n(b_ce0_n), .b_ce1(b_ce1), .b_lane_n(b_lane_n), .b_rw(b_rw),
        .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_drive(b_drive)
    );

    function automatic logic [17:0] pattern(int i);
        logic [17:0] v;
        v = 18'(i * 3079 + 511) ^ 18'(i << 9);
        return v;
    endfunction

    // Advance one edge; outputs are settled 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [17:0] oldv, newv;
        // R11: reset state, drivers off.
        step(); step(); step();
        check("R11 reset drive A", 18'(a_drive), 18'd0);
        check("R11 reset drive B", 18'(b_drive), 18'd0);
        rst_n = 1'b1;

        // Fill the whole array from port A, both lanes (R12 reaches top address).
        a_ce0_n = 1'b0; a_rw = 1'b0; a_lane_n = 2'b00;
        for (int i = 0; i < DEPTH; i++) begin
            a_addr = AW'(i); a_wdata = pattern(i); model[i] = pattern(i);
            step();
        end
        a_ce0_n = 1'b1; a_rw = 1'b1;

        // R5 R10 R12: flow-through sweep from port B.
        b_ce0_n = 1'b0; b_rw = 1'b1; b_pipe = 1'b0; b_lane_n = 2'b00;
        for (int i = 0; i < DEPTH; i++) begin
            b_addr = AW'(i);
            step();
            check("R5 flow sweep data", b_rdata, model[i]);
            check("R3 flow sweep drive", 18'(b_drive), 18'd3);
        end
        b_ce0_n = 1'b1;

        // R6: pipelined sweep from port A, one edge later.
        a_ce0_n = 1'b0; a_rw = 1'b1; a_pipe = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            a_addr = AW'(i);
            step();
            if (i > 0) check("R6 pipe sweep data", a_rdata, model[i-1]);
        end
        step();
        check("R6 pipe sweep last", a_rdata, model[DEPTH-1]);
        a_ce0_n = 1'b1; a_pipe = 1'b0;

        // R2: lane-masked writes from port B.
        b_ce0_n = 1'b0; b_rw = 1'b0;
        b_addr = 5; b_lane_n = 2'b01; b_wdata = 18'h2AAAA;
        model[5] = {b_wdata[17:9], model[5][8:0]};
        step();
        b_addr = 6; b_lane_n = 2'b10; b_wdata = 18'h15555;
        model[6] = {model[6][17:9], b_wdata[8:0]};
        step();
        b_ce0_n = 1'b1; b_rw = 1'b1; b_lane_n = 2'b00;
        a_ce0_n = 1'b0; a_rw = 1'b1;
        a_addr = 5; step();
        check("R2 upper only write", a_rdata, model[5]);
        a_addr = 6; step();
        check("R2 lower only write", a_rdata, model[6]);

        // R1: writes with either enable inactive are dropped.
        a_rw = 1'b0; a_ce0_n = 1'b1; a_ce1 = 1'b1; a_addr = 7; a_wdata = 18'h3FFFF;
        step();
        a_ce0_n = 1'b0; a_ce1 = 1'b0; a_addr = 8; a_wdata = 18'h3FFFF;
        step();
        check("R1 deselected drive", 18'(a_drive), 18'd0);
        a_ce1 = 1'b1; a_rw = 1'b1;
        a_addr = 7; step();
        check("R1 ce0 high no write", a_rdata, model[7]);
        a_addr = 8; step();
        check("R1 ce1 low no write", a_rdata, model[8]);

        // R3 R8: read of the lower lane only.
        a_addr = 9; a_lane_n = 2'b10; step();
        check("R8 lower lane drive", 18'(a_drive), 18'd1);
        check("R3 upper lane zero", a_rdata, {9'd0, model[9][8:0]});

        // R4: output enable without a clock.
        a_lane_n = 2'b00; step();
        check("R4 drive on", 18'(a_drive), 18'd3);
        a_oe_n = 1'b1; #1;
        check("R4 oe high drive", 18'(a_drive), 18'd0);
        check("R4 oe high data", a_rdata, 18'd0);
        a_oe_n = 1'b0; #1;
        check("R4 oe low drive", 18'(a_drive), 18'd3);

        // R7: pipelined enable takes two edges each way.
        a_pipe = 1'b1; a_addr = 3; step(); step();
        check("R7 pipe steady", 18'(a_drive), 18'd3);
        a_ce0_n = 1'b1; step();
        check("R7 pipe deselect edge1", 18'(a_drive), 18'd3);
        step();
        check("R7 pipe deselect edge2", 18'(a_drive), 18'd0);
        a_ce0_n = 1'b0; step();
        check("R7 pipe reselect edge1", 18'(a_drive), 18'd0);
        step();
        check("R7 pipe reselect edge2", 18'(a_drive), 18'd3);
        check("R7 pipe reselect data", a_rdata, model[3]);

        // R7 R1: flow-through enable takes one edge.
        b_ce0_n = 1'b0; b_pipe = 1'b0; b_addr = 4; step();
        check("R7 flow steady", 18'(b_drive), 18'd3);
        b_ce0_n = 1'b1; step();
        check("R1 flow deselect", 18'(b_drive), 18'd0);
        b_ce0_n = 1'b0; step();
        check("R7 flow reselect", 18'(b_drive), 18'd3);

        // R8: lane select takes one edge in pipelined mode too.
        a_lane_n = 2'b01; step();
        check("R8 pipe lane drive", 18'(a_drive), 18'd2);
        check("R8 pipe lane data", a_rdata, {model[3][17:9], 9'd0});
        a_lane_n = 2'b00;

        // R9: mode pin switches stages without a clock; port B untouched.
        a_addr = 10; step();
        a_addr = 11; step();
        check("R9 pipe stage data", a_rdata, model[10]);
        a_pipe = 1'b0; #1;
        check("R9 flow stage data", a_rdata, model[11]);
        check("R9 other port drive", 18'(b_drive), 18'd3);

        // R10: cross-port write then read.
        oldv = model[20]; newv = 18'h0F0F0;
        a_rw = 1'b0; a_addr = 20; a_wdata = newv; a_lane_n = 2'b00;
        b_addr = 20; b_rw = 1'b1;
        step();
        model[20] = newv;
        checks++;
        if (b_rdata !== oldv && b_rdata !== newv) begin
            errors++;
            $display("FAIL R10 same cycle: actual %h expected %h or %h", b_rdata, oldv, newv);
        end
        a_ce0_n = 1'b1; a_rw = 1'b1;
        step();
        check("R10 later read new", b_rdata, newv);

        // R11: reset clears drivers but keeps contents.
        rst_n = 1'b0; step(); step();
        check("R11 mid reset drive B", 18'(b_drive), 18'd0);
        rst_n = 1'b1;
        b_addr = 0; step();
        check("R11 contents kept", b_rdata, model[0]);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule